// File: doc/BRIEF.md
# Synchronous Shift-Register Serial Engine

This block moves one byte at a time over a three-wire synchronous link: a shift clock that it drives, a data output, and a data input. It is the shift-register mode of a small controller's serial port. Every edge sits at a fixed number of oscillator cycles from the start of the transfer. One bit lasts twelve oscillator cycles. The shift clock is low for the first six cycles of a bit and high for the last six. Bytes travel least-significant bit first. A transmit transfer drives the data line and changes it two cycles after each rising shift-clock edge, so the receiver has ten cycles of setup and two of hold. A receive transfer samples the input line on the cycle edge at which the shift clock rises.

The host starts a transfer with a one-cycle strobe: a transmit strobe together with a byte, or a receive strobe. The transfer runs by itself, and then a one-cycle done flag is raised. The received byte is held on its output until the next receive transfer completes. While a transfer is in progress, strobes are ignored.

The control is a four-state machine:
- `ST_IDLE`: waiting. It goes to `ST_LEAD` on an accepted strobe.
- `ST_LEAD`: four cycles with the clock high, to give the first bit its setup time. It goes to `ST_SHIFT` after the fourth cycle.
- `ST_SHIFT`: eight bit periods. It goes to `ST_DONE` after the last cycle of bit 7.
- `ST_DONE`: one cycle that raises the done flag. It always returns to `ST_IDLE`.

Top module: `sync_shift_port`

## Requirements
- R1: During and after reset, before any strobe: `sclk`=1, `sdo`=1, `sdo_en`=0, `done`=0, `rx_byte`=0x00.
- R2: The shift clock is 1 whenever no bit is being shifted. Each of the 8 bit periods is 12 cycles, with `sclk`=0 for cycles 0–5 and `sclk`=1 for cycles 6–11 of the period.
- R3: A strobe is accepted at a clock edge. The 4 cycles after that edge keep `sclk`=1, and the first low cycle is the 5th cycle after acceptance.
- R4: A transmit sends `tx_byte` bit 0 first and bit 7 last. `sdo_en` is 1 from the cycle after acceptance up to, but not including, the done cycle. `sdo` is 1 whenever `sdo_en` is 0.
- R5: For a transmit, `sdo` shows bit 0 from the cycle after acceptance. Bit k+1 appears in cycle 8 of bit period k, which is two cycles after the rising edge. The last bit is held until the done cycle.
- R6: A receive captures `sdi` as it stands in cycle 5 of each bit period, at the edge where `sclk` rises. The first captured bit becomes `rx_byte` bit 0. `rx_byte` changes only in a done cycle that ends a receive, and a transmit leaves it unchanged.
- R7: `done` is 1 for exactly one cycle, the 101st cycle after acceptance, which follows the 8th bit period. `rx_byte` holds the new byte from that cycle on.
- R8: A strobe that arrives in any cycle other than an idle cycle, including the done cycle, is ignored: the transfer in progress and its outputs are unchanged, and no new transfer starts.
- R9: If both strobes arrive in the same idle cycle, the transmit is started.
- R10: A strobe in the idle cycle directly after the done cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-rate clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_start | input | 1 | One-cycle strobe that starts a transmit |
| tx_byte | input | 8 | Byte to send, sampled together with `tx_start` |
| rx_start | input | 1 | One-cycle strobe that starts a receive |
| sdi | input | 1 | Serial data input |
| sclk | output | 1 | Shift clock, high when idle |
| sdo | output | 1 | Serial data output |
| sdo_en | output | 1 | High while a transmit drives the data line |
| done | output | 1 | One-cycle end-of-transfer pulse |
| rx_byte | output | 8 | Last byte received |

## Verification
Two pairs of events can fall in the same cycle. The first is a new strobe arriving in the done cycle, where the finishing transfer and a possible start meet. The second is both strobes asserted together in an idle cycle. The bench places a strobe exactly on the cycle where `done` is seen, and another one cycle later. It also pulses both strobes at once. A reference model, written as a cycle counter, predicts every output on every cycle. The bench judges whether the done-cycle strobe was dropped, whether the next-cycle strobe started a new transfer, and whether transmit won the double strobe, by `sdo_en` and `sclk` in the cycles that follow.

// File: rtl/ssp_pkg.sv
package ssp_pkg;
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_SHIFT = 2'd2,
        ST_DONE  = 2'd3
    } ssp_state_t;

    typedef enum logic {
        DIR_TX = 1'b0,
        DIR_RX = 1'b1
    } ssp_dir_t;
endpackage

// File: rtl/ssp_bit_timer.sv
// Phase and bit counters for the shift clock; also times the lead-in.
module ssp_bit_timer #(
    parameter int HALF = 6,
    parameter int BITS = 8,
    parameter int LEAD = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      clr,
    input  logic                      run,
    output logic [$clog2(BITS)-1:0]   bit_idx,
    output logic                      low_phase,
    output logic                      lead_end,
    output logic                      rise_edge,
    output logic                      data_edge,
    output logic                      last_edge
);
    localparam int PERIOD = 2 * HALF;
    localparam int PW     = $clog2(PERIOD);
    localparam int BW     = $clog2(BITS);

    logic [PW-1:0] phase;

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            phase   <= '0;
            bit_idx <= '0;
        end else if (run) begin
            if (phase == PW'(PERIOD - 1)) begin
                phase   <= '0;
                bit_idx <= bit_idx + 1'b1;
            end else begin
                phase <= phase + 1'b1;
            end
        end
    end

    always_comb begin
        low_phase = (phase < PW'(HALF));
        lead_end  = (phase == PW'(LEAD - 1));
        rise_edge = (phase == PW'(HALF - 1));
        data_edge = (phase == PW'(HALF + 1));
        last_edge = (phase == PW'(PERIOD - 1)) && (bit_idx == BW'(BITS - 1));
    end
endmodule

// File: rtl/ssp_shifter.sv
// Shared shift register: loads the transmit byte, advances it, or collects input bits.
module ssp_shifter #(
    parameter int BITS = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [BITS-1:0] load_val,
    input  logic            capture,
    input  logic            advance,
    input  logic            finish,
    input  logic            sdi,
    output logic            sdo_bit,
    output logic [BITS-1:0] word
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word    <= '0;
            sdo_bit <= 1'b1;
        end else if (load) begin
            word    <= load_val;
            sdo_bit <= load_val[0];
        end else if (finish) begin
            sdo_bit <= 1'b1;
        end else if (capture) begin
            word <= {sdi, word[BITS-1:1]};
        end else if (advance) begin
            word    <= {1'b1, word[BITS-1:1]};
            sdo_bit <= word[1];
        end
    end
endmodule

// File: rtl/sync_shift_port.sv
module sync_shift_port
    import ssp_pkg::*;
#(
    parameter int HALF = 6,
    parameter int BITS = 8,
    parameter int LEAD = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            tx_start,
    input  logic [BITS-1:0] tx_byte,
    input  logic            rx_start,
    input  logic            sdi,
    output logic            sclk,
    output logic            sdo,
    output logic            sdo_en,
    output logic            done,
    output logic [BITS-1:0] rx_byte
);
    localparam int BW = $clog2(BITS);

    ssp_state_t      state, state_nx;
    ssp_dir_t        dir;
    logic            accept, tm_clr, tm_run;
    logic [BW-1:0]   bit_idx;
    logic            low_phase, lead_end, rise_edge, data_edge, last_edge;
    logic            sh_capture, sh_advance, sh_finish, sdo_bit;
    logic [BITS-1:0] word, load_val;

    // next state
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (tx_start || rx_start) state_nx = ST_LEAD;
            ST_LEAD:  if (lead_end)             state_nx = ST_SHIFT;
            ST_SHIFT: if (last_edge)            state_nx = ST_DONE;
            ST_DONE:                            state_nx = ST_IDLE;
            default:                            state_nx = ST_IDLE;
        endcase
    end

    // state register and transfer direction
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            dir   <= DIR_TX;
        end else begin
            state <= state_nx;
            if (accept) dir <= tx_start ? DIR_TX : DIR_RX;
        end
    end

    always_comb begin
        accept     = (state == ST_IDLE) && (tx_start || rx_start);
        load_val   = tx_start ? tx_byte : '1;
        tm_clr     = (state == ST_IDLE) || (state == ST_DONE) ||
                     ((state == ST_LEAD) && lead_end);
        tm_run     = (state == ST_LEAD) || (state == ST_SHIFT);
        sh_capture = (state == ST_SHIFT) && rise_edge && (dir == DIR_RX);
        sh_advance = (state == ST_SHIFT) && data_edge && (dir == DIR_TX) &&
                     (bit_idx != BW'(BITS - 1));
        sh_finish  = (state == ST_SHIFT) && last_edge;
    end

    ssp_bit_timer #(.HALF(HALF), .BITS(BITS), .LEAD(LEAD)) u_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (tm_clr),
        .run       (tm_run),
        .bit_idx   (bit_idx),
        .low_phase (low_phase),
        .lead_end  (lead_end),
        .rise_edge (rise_edge),
        .data_edge (data_edge),
        .last_edge (last_edge)
    );

    ssp_shifter #(.BITS(BITS)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .load_val (load_val),
        .capture  (sh_capture),
        .advance  (sh_advance),
        .finish   (sh_finish),
        .sdi      (sdi),
        .sdo_bit  (sdo_bit),
        .word     (word)
    );

    // received byte register
    always_ff @(posedge clk) begin
        if (!rst_n)                          rx_byte <= '0;
        else if (sh_finish && dir == DIR_RX) rx_byte <= word;
    end

    // outputs
    always_comb begin
        sclk   = !((state == ST_SHIFT) && low_phase);
        sdo    = sdo_bit;
        sdo_en = (dir == DIR_TX) && ((state == ST_LEAD) || (state == ST_SHIFT));
        done   = (state == ST_DONE);
    end
endmodule

// File: rtl/ssp_checker.sv
module ssp_checker #(
    parameter int BITS = 8
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sclk,
    input logic            sdo,
    input logic            sdo_en,
    input logic            done,
    input logic [BITS-1:0] rx_byte
);
    p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_sclk_high_done_r2: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> sclk);

    p_sdo_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(sclk) && sdo_en) |=> $stable(sdo));

    p_sdo_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_en |-> sdo);

    p_rx_only_at_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(rx_byte) |-> done);

    p_no_drive_in_done_r4: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !sdo_en);
endmodule

bind sync_shift_port ssp_checker #(.BITS(BITS)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sclk    (sclk),
    .sdo     (sdo),
    .sdo_en  (sdo_en),
    .done    (done),
    .rx_byte (rx_byte)
);

// File: tb/sim_sync_shift_port.sv
`timescale 1ns/1ps
module sim_sync_shift_port;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tx_start = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       rx_start = 1'b0;
    logic       sdi = 1'b0;
    logic       sclk, sdo, sdo_en, done;
    logic [7:0] rx_byte;

    int nchk = 0;
    int nfail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    sync_shift_port u0 (
        .clk(clk), .rst_n(rst_n), .tx_start(tx_start), .tx_byte(tx_byte),
        .rx_start(rx_start), .sdi(sdi), .sclk(sclk), .sdo(sdo),
        .sdo_en(sdo_en), .done(done), .rx_byte(rx_byte)
    );

    // reference model: mk = cycles since acceptance, -1 when idle
    int         mk = -1;
    bit         mtx = 1'b0;
    logic [7:0] mdata = 8'h00;
    logic [7:0] mcol = 8'h00;
    logic [7:0] mrx = 8'h00;

    always @(posedge clk) begin
        if (!rst_n) begin
            mk  = -1;
            mrx = 8'h00;
        end else if (mk < 0) begin
            if (tx_start) begin
                mk = 0; mtx = 1'b1; mdata = tx_byte;
            end else if (rx_start) begin
                mk = 0; mtx = 1'b0;
            end
        end else begin
            if (!mtx && mk >= 4 && mk < 100 && ((mk - 4) % 12) == 5)
                mcol[(mk - 4) / 12] = sdi;
            if (!mtx && mk == 99) mrx = mcol;
            mk = (mk == 100) ? -1 : mk + 1;
        end
    end

    function automatic logic e_sclk();
        if (mk < 4 || mk >= 100) return 1'b1;
        return (((mk - 4) % 12) >= 6);
    endfunction

    function automatic logic e_en();
        return mtx && mk >= 0 && mk < 100;
    endfunction

    function automatic logic e_sdo();
        int b, p, idx;
        if (!e_en()) return 1'b1;
        if (mk < 4) return mdata[0];
        b = (mk - 4) / 12;
        p = (mk - 4) % 12;
        idx = (p >= 8 && b < 7) ? b + 1 : b;
        return mdata[idx];
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s: actual %h expected %h (t=%0t)", tag, act, exp, $time);
        end
    endtask

    // cycle-by-cycle comparison
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            chk("R2/R3 sclk",  {7'd0, sclk},   {7'd0, e_sclk()});
            chk("R4 sdo_en",   {7'd0, sdo_en}, {7'd0, e_en()});
            chk("R5 sdo",      {7'd0, sdo},    {7'd0, e_sdo()});
            chk("R7 done",     {7'd0, done},   {7'd0, 1'(mk == 100)});
            chk("R6 rx_byte",  rx_byte,        mrx);
        end
    end

    // serial input stimulus
    logic [15:0] lfsr = 16'hACE1;
    always @(negedge clk) begin
        lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        sdi  <= lfsr[15];
    end

    task automatic pulse_tx(logic [7:0] b);
        tx_byte = b; tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
    endtask

    task automatic pulse_rx();
        rx_start = 1'b1;
        @(negedge clk);
        rx_start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done) @(negedge clk);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 sclk",    {7'd0, sclk},   8'h01);
        chk("R1 sdo",     {7'd0, sdo},    8'h01);
        chk("R1 sdo_en",  {7'd0, sdo_en}, 8'h00);
        chk("R1 done",    {7'd0, done},   8'h00);
        chk("R1 rx_byte", rx_byte,        8'h00);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R1 idle after release", {6'd0, sclk, sdo}, 8'h03);

        // transmit, with the lead-in checked directly
        pulse_tx(8'hA5);
        repeat (3) @(negedge clk);
        chk("R3 last lead cycle high", {7'd0, sclk}, 8'h01);
        @(negedge clk);
        chk("R3 first low cycle", {7'd0, sclk}, 8'h00);
        wait_done();

        // strobe in the done cycle is ignored
        tx_byte = 8'h11; tx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0;
        chk("R8 done-cycle strobe ignored", {7'd0, sdo_en}, 8'h00);
        repeat (6) @(negedge clk);
        chk("R8 still idle", {6'd0, sdo_en, sclk}, 8'h01);

        // receive, with a transmit strobe while busy
        pulse_rx();
        repeat (40) @(negedge clk);
        pulse_tx(8'h00);
        chk("R8 busy strobe ignored", {7'd0, sdo_en}, 8'h00);
        wait_done();
        chk("R6 rx_byte at done", rx_byte, mrx);

        // back-to-back start in the idle cycle after done
        @(negedge clk);
        pulse_tx(8'h3C);
        chk("R10 next-cycle start accepted", {7'd0, sdo_en}, 8'h01);
        repeat (30) @(negedge clk);
        pulse_rx();
        chk("R8 rx strobe during tx ignored", {7'd0, sdo_en}, 8'h01);
        wait_done();
        @(negedge clk);

        // both strobes together
        tx_byte = 8'hFF; tx_start = 1'b1; rx_start = 1'b1;
        @(negedge clk);
        tx_start = 1'b0; rx_start = 1'b0;
        chk("R9 transmit wins", {7'd0, sdo_en}, 8'h01);
        wait_done();
        @(negedge clk);

        pulse_tx(8'h00);
        wait_done();
        @(negedge clk);
        pulse_rx();
        wait_done();
        repeat (3) @(negedge clk);

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            nchk++;
            nfail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    end
endmodule